// File: doc/BRIEF.md
# Interrupt Aggregator with Deassertion Holdoff

This block merges a set of level-sensitive interrupt lines, a software-raised interrupt and a wake line into a single active-high, registered interrupt request. Each line is latched into a status bit. Software clears a status bit by writing 1 to it. A per-bit enable mask selects which latched bits may drive the request, and a global enable gates every line except wake.

After the request falls, a programmable holdoff keeps it low for a minimum time, so that the receiver sees a clean low period. The holdoff is counted in ticks of a clock prescaler (`TICK_DIV` cycles per tick, 2500 at 250 MHz for a 10 µs tick). Wake bypasses both the holdoff and the global enable. A register port with four word addresses gives access to status, enables, configuration and control. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all four registers read 0, `irq_o` is 0 and the holdoff-active flag (config bit 17) is 0.
- R2: The status register (address 0) latches each source while it is high: bits [NUM_SRC-1:0] hold `src_i`, bit NUM_SRC holds the software interrupt and bit NUM_SRC+1 holds `wake_i`.
- R3: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged. A source that is still high at the clearing edge keeps its bit set.
- R4: The software status bit sets only when enable bit NUM_SRC (address 1) changes from 0 to 1. Rewriting it while it is already 1 does not set the status bit again.
- R5: A latched status bit can drive `irq_o` only when its bit in the enable register (address 1) is 1.
- R6: Config bit 16 (address 2) reads 1 whenever any status bit is set together with its enable bit. The holdoff and the global enable do not affect it.
- R7: When control bit 0 (address 3, the global enable) is 0, no line except wake can drive `irq_o`.
- R8: An enabled, latched wake bit (enable bit NUM_SRC+1) drives `irq_o` high on the next cycle, even while the global enable is 0 or a holdoff is running.
- R9: When `irq_o` falls while config bits [HOLD_W-1:0] hold N≠0, config bit 17 reads 1 during the holdoff. A pending non-wake line cannot raise `irq_o` earlier than N×TICK_DIV+1 cycles after the cycle of the fall.
- R10: With N=0 no holdoff runs, and a line that becomes pending right after a fall raises `irq_o` two cycles later.
- R11: `irq_o` is registered: it rises on the cycle after an enabled status bit is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt sources |
| wake_i | input | 1 | Wake event line |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The bench measures the exact length of the low gap after a fall, both with a holdoff programmed and with a holdoff of zero. A timer that starts one cycle late, counts one tick short or ignores a zero setting shows up as a gap of the wrong length. It sends a wake pulse in the middle of a holdoff and while the global enable is off, which catches a design that gates wake like the other lines. It also clears a status bit while its source is still high, and rewrites an enable that is already set. These two cases expose a clear that wins over the set, and a software interrupt raised on a level instead of an edge.

// File: rtl/irq_agg_pkg.sv
// Shared register addresses and readback bit positions for the interrupt
// aggregator. Assumes a two-bit word address space.
package irq_agg_pkg;
    typedef enum logic [1:0] {
        REG_STATUS  = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_CONFIG  = 2'd2,
        REG_CONTROL = 2'd3
    } reg_sel_e;

    localparam int AGG_BIT  = 16;
    localparam int HOLD_BIT = 17;
endpackage

// File: rtl/irq_agg_ctrl.sv
// Control registers: enable mask, holdoff setting and global enable.
// Also detects the 0-to-1 change of the software interrupt enable bit.
// Assumes writes are single-cycle strobes and SW >= 3.
module irq_agg_ctrl #(
    parameter int SW     = 6,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [SW-1:0]     en_q,
    output logic [HOLD_W-1:0] cfg_q,
    output logic              gen_en_q,
    output logic              soft_rise
);
    import irq_agg_pkg::*;

    localparam int SOFT_IDX = SW - 2;

    logic soft_prev_q;

    // Register writes into enable, config and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            cfg_q    <= '0;
            gen_en_q <= 1'b0;
        end else if (wr) begin
            case (reg_sel_e'(addr))
                REG_ENABLE:  en_q     <= wdata[SW-1:0];
                REG_CONFIG:  cfg_q    <= wdata[HOLD_W-1:0];
                REG_CONTROL: gen_en_q <= wdata[0];
                default:     ;
            endcase
        end
    end

    // Remember the previous software enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_prev_q <= 1'b0;
        else        soft_prev_q <= en_q[SOFT_IDX];
    end

    // One-cycle pulse on the rising edge of the software enable.
    always_comb soft_rise = en_q[SOFT_IDX] & ~soft_prev_q;
endmodule

// File: rtl/irq_agg_status.sv
// Sticky status bits with write-1-to-clear. A set in the same cycle as a
// clear wins. Bit order: level sources, software, wake.
module irq_agg_status #(
    parameter int NUM_SRC = 4,
    localparam int SW     = NUM_SRC + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               soft_set,
    input  logic               wake,
    input  logic               clr_we,
    input  logic [SW-1:0]      clr_mask,
    output logic [SW-1:0]      st_q
);
    logic [SW-1:0] set_vec;

    // Gather the per-bit set requests.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign set_vec[i] = src[i];
        end
    endgenerate
    assign set_vec[SW-2] = soft_set;
    assign set_vec[SW-1] = wake;

    // Latch sets, apply write-1 clears; set dominates.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~(clr_we ? clr_mask : '0)) | set_vec;
    end
endmodule

// File: rtl/irq_agg_holdoff.sv
// Holdoff timer. On start it loads the programmed tick count and restarts
// the prescaler. It counts down once every TICK_DIV cycles and is active
// while the count is nonzero. Assumes TICK_DIV >= 2.
module irq_agg_holdoff #(
    parameter int HOLD_W   = 8,
    parameter int TICK_DIV = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HOLD_W-1:0] load_val,
    output logic              active
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0]     presc_q;
    logic [HOLD_W-1:0] cnt_q;

    // Load on start, otherwise step the prescaler and count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            presc_q <= '0;
            cnt_q   <= load_val;
        end else if (cnt_q != '0) begin
            if (presc_q == LAST) begin
                presc_q <= '0;
                cnt_q   <= cnt_q - 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    // The holdoff runs while ticks remain.
    always_comb active = (cnt_q != '0);
endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top. Merges latched, enabled lines into a
// registered IRQ, applies the global enable and the post-deassertion
// holdoff to every line except wake, and serves a four-word register port.
// Assumes NUM_SRC + 2 <= 16 and HOLD_W <= 16.
module irq_aggregator #(
    parameter int NUM_SRC  = 4,
    parameter int HOLD_W   = 8,
    parameter int TICK_DIV = 2500
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wake_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_o
);
    import irq_agg_pkg::*;

    localparam int SW = NUM_SRC + 2;

    logic [SW-1:0]     en_q;
    logic [HOLD_W-1:0] cfg_q;
    logic              gen_en_q;
    logic              soft_rise;
    logic [SW-1:0]     st_q;
    logic              hold_active;
    logic              wake_hit, norm_hit, agg, irq_next, irq_q, fall;

    irq_agg_ctrl #(.SW(SW), .HOLD_W(HOLD_W)) u_ctrl (
        .clk(clk_i), .rst_n(rst_ni), .wr(reg_wr_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .en_q(en_q), .cfg_q(cfg_q),
        .gen_en_q(gen_en_q), .soft_rise(soft_rise)
    );

    irq_agg_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk(clk_i), .rst_n(rst_ni), .src(src_i), .soft_set(soft_rise),
        .wake(wake_i),
        .clr_we(reg_wr_i && (reg_sel_e'(reg_addr_i) == REG_STATUS)),
        .clr_mask(reg_wdata_i[SW-1:0]), .st_q(st_q)
    );

    irq_agg_holdoff #(.HOLD_W(HOLD_W), .TICK_DIV(TICK_DIV)) u_hold (
        .clk(clk_i), .rst_n(rst_ni), .start(fall), .load_val(cfg_q),
        .active(hold_active)
    );

    // Combine enabled lines; wake bypasses gating and holdoff.
    always_comb begin
        wake_hit = st_q[SW-1] & en_q[SW-1];
        norm_hit = |(st_q[SW-2:0] & en_q[SW-2:0]);
        agg      = |(st_q & en_q);
        irq_next = wake_hit | (gen_en_q & ~hold_active & norm_hit);
        fall     = irq_q & ~irq_next;
    end

    // Register the request output.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_next;
    end
    assign irq_o = irq_q;

    // Read data multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_sel_e'(reg_addr_i))
            REG_STATUS:  reg_rdata_o[SW-1:0] = st_q;
            REG_ENABLE:  reg_rdata_o[SW-1:0] = en_q;
            REG_CONFIG: begin
                reg_rdata_o[HOLD_W-1:0] = cfg_q;
                reg_rdata_o[AGG_BIT]    = agg;
                reg_rdata_o[HOLD_BIT]   = hold_active;
            end
            REG_CONTROL: reg_rdata_o[0] = gen_en_q;
            default:     ;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Checker for irq_aggregator: temporal properties on the request, the
// holdoff and the status bits. It is bound into every instance of the top.
module irq_aggregator_chk #(
    parameter int SW     = 6,
    parameter int HOLD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [SW-1:0]     st,
    input logic [SW-1:0]     en,
    input logic [HOLD_W-1:0] cfg,
    input logic              gen_en,
    input logic              hold_active,
    input logic              wr,
    input logic [1:0]        addr,
    input logic [31:0]       wdata
);
    assert_wake_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st[SW-1] && en[SW-1]) |=> irq);

    assert_holdoff_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !(st[SW-1] && en[SW-1])) |=> !irq);

    assert_holdoff_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq) && ($past(cfg) != '0)) |-> hold_active);

    assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !(st[SW-1] && en[SW-1])) |=> !irq);

    assert_enable_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((en[SW-2:0] == '0) && !(st[SW-1] && en[SW-1])) |=> !irq);

    assert_soft_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en[SW-2]) |=> st[SW-2]);

    assert_w1c_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0) |=>
        ((st & $past(st) & ~$past(wdata[SW-1:0])) == ($past(st) & ~$past(wdata[SW-1:0]))));

    assert_zero_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == '0 && !hold_active) |=> !hold_active);
endmodule

bind irq_aggregator irq_aggregator_chk #(.SW(SW), .HOLD_W(HOLD_W)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .irq(irq_q), .st(st_q), .en(en_q),
    .cfg(cfg_q), .gen_en(gen_en_q), .hold_active(hold_active),
    .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int NS  = 4;
    localparam int SW  = NS + 2;
    localparam int DIV = 8;
    localparam int SOFT = NS;
    localparam int WAKE = NS + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          wake = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_aggregator #(.NUM_SRC(NS), .HOLD_W(8), .TICK_DIV(DIV)) uut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wake_i(wake),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic exp_irq(logic [SW-1:0] st, logic [SW-1:0] en, logic gen);
        return (st[WAKE] & en[WAKE]) | (gen & |(st[SW-2:0] & en[SW-2:0]));
    endfunction

    function automatic logic exp_agg(logic [SW-1:0] st, logic [SW-1:0] en);
        return |(st & en);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_src(logic [NS-1:0] m);
        src = m;
        @(negedge clk);
        src = '0;
    endtask

    // Count cycles from a fall of irq until irq rises again; pend source 0 right after the fall.
    task automatic gap_after_clear(logic [SW-1:0] clr, output int k, output logic [31:0] cfg_rd);
        int guard = 0;
        wr_reg(2'd0, 32'(clr));
        while (irq && guard < 20) begin @(negedge clk); guard++; end
        src = 4'b0001;
        @(negedge clk);
        src = '0;
        k = 1;
        rd_reg(2'd2, cfg_rd);
        while (!irq && k < 200) begin @(negedge clk); k++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] cfg_rd;
        int k;
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), d);
            check("R1 reg reset", d, 32'h0);
        end
        check("R1 irq reset", 32'(irq), 32'h0);

        // Random phase: holdoff 0, global enable on
        wr_reg(2'd3, 32'h1);
        for (int it = 0; it < 20; it++) begin
            logic [NS-1:0] m;
            logic [NS-1:0] e;
            logic [SW-1:0] st_e, en_e;
            m = NS'($urandom);
            e = NS'($urandom);
            wr_reg(2'd0, 32'h3F);
            wr_reg(2'd1, 32'(e));
            pulse_src(m);
            tick(2);
            st_e = {2'b00, m};
            en_e = {2'b00, e};
            rd_reg(2'd0, d);
            check("R2 random status", d, 32'(st_e));
            check("R5 random irq", 32'(irq), 32'(exp_irq(st_e, en_e, 1'b1)));
            rd_reg(2'd2, d);
            check("R6 random aggregate", 32'(d[16]), 32'(exp_agg(st_e, en_e)));
        end
        wr_reg(2'd0, 32'h3F);
        tick(2);

        // R3: partial clear
        wr_reg(2'd1, 32'h0);
        pulse_src(4'b1010);
        wr_reg(2'd0, 32'h2);
        rd_reg(2'd0, d);
        check("R3 partial clear", d, 32'h8);
        // R3: set wins while source still high
        src = 4'b0001;
        tick(1);
        wr_reg(2'd0, 32'h1);
        rd_reg(2'd0, d);
        check("R3 set wins", d[3:0], 32'h9);
        src = '0;
        wr_reg(2'd0, 32'h3F);

        // R11: registered rise, one cycle after latch
        wr_reg(2'd1, 32'h4);
        src = 4'b0100;
        @(posedge clk); #1;
        check("R11 not yet", 32'(irq), 32'h0);
        @(posedge clk); #1;
        check("R11 risen", 32'(irq), 32'h1);
        @(negedge clk);
        src = '0;
        wr_reg(2'd0, 32'h3F);
        tick(2);

        // R4: software interrupt edge
        wr_reg(2'd1, 32'(1 << SOFT));
        tick(2);
        rd_reg(2'd0, d);
        check("R4 soft set", 32'(d[SOFT]), 32'h1);
        check("R4 soft irq", 32'(irq), 32'h1);
        wr_reg(2'd0, 32'(1 << SOFT));
        wr_reg(2'd1, 32'(1 << SOFT));
        tick(2);
        rd_reg(2'd0, d);
        check("R4 no reset on hold", 32'(d[SOFT]), 32'h0);
        wr_reg(2'd1, 32'h0);
        tick(2);

        // R7/R6/R8: global enable off, pending source, then wake
        wr_reg(2'd3, 32'h0);
        wr_reg(2'd1, 32'(1 | (1 << WAKE)));
        pulse_src(4'b0001);
        tick(2);
        check("R7 gated irq", 32'(irq), 32'h0);
        rd_reg(2'd2, d);
        check("R6 aggregate while gated", 32'(d[16]), 32'h1);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        @(negedge clk);
        check("R8 wake while gated", 32'(irq), 32'h1);
        wr_reg(2'd0, 32'h3F);
        wr_reg(2'd3, 32'h1);
        tick(3);

        // R10: zero holdoff gap
        wr_reg(2'd1, 32'h1);
        pulse_src(4'b0001);
        tick(2);
        gap_after_clear(6'h01, k, cfg_rd);
        check("R10 hold flag idle", 32'(cfg_rd[17]), 32'h0);
        check("R10 gap", 32'(k), 32'd2);

        // R9: holdoff gap with N=3
        wr_reg(2'd2, 32'd3);
        tick(2);
        gap_after_clear(6'h01, k, cfg_rd);
        check("R9 hold flag", 32'(cfg_rd[17]), 32'h1);
        check("R6 aggregate during hold", 32'(cfg_rd[16]), 32'h1);
        check("R9 gap", 32'(k), 32'(3 * DIV + 1));

        // R8: wake during holdoff
        wr_reg(2'd1, 32'(1 | (1 << WAKE)));
        wr_reg(2'd0, 32'h01);
        k = 0;
        while (irq && k < 20) begin @(negedge clk); k++; end
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        @(negedge clk);
        rd_reg(2'd2, d);
        check("R9 hold still running", 32'(d[17]), 32'h1);
        check("R8 wake during hold", 32'(irq), 32'h1);
        wr_reg(2'd0, 32'h3F);
        tick(3);
        check("R9 blocked after wake clear", 32'(irq), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule